// File: doc/BRIEF.md
# Word-Serial Block Cipher Host Interface

This block is a register-mapped front end for a 128-bit block cipher. A host moves one block in as four 32-bit writes to a single input address, and the most significant word comes first. After the fourth write the block starts the cipher core on its own. When the result is ready it raises a sticky completion flag. The host then takes the result back as four 32-bit reads from a single output address, again most significant word first. The completion flag stays set until the host writes a clear bit in the control register.

Around the core the block applies either ECB or CBC chaining, in both the encrypt and the decrypt direction. In CBC mode the four chaining-vector registers are updated as each block completes. Software reads them back to save a stream's context and writes them to restore it. The core itself is a placeholder built into the block: a fixed-latency, invertible transform of a rotate and an XOR with the key input. This keeps the block self-contained.

Address map, as word addresses on `addr_i`:
- 0: control
- 1: status
- 2: data-in
- 3: data-out
- 4 to 7: chaining vector, where 4 holds the most significant word

Top module: `cph_host`

## Requirements
- R1: After reset, the control and status registers read as zero.
- R2: The control register holds the following fields, and fields 0 to 5 read back as written:
  - bit 0: enable
  - bits 2:1: mode. 2'b10 selects decryption; any other value selects encryption.
  - bits 5:3: chaining. 3'b001 selects CBC; any other value selects ECB.
  - bit 7: write-1 clear of the completion flag. Always reads 0.
  - bit 8: write-1 clear of the error flag. Always reads 0.
- R3: With enable set, four writes to data-in form one block with the first word as bits 127:96, and the fourth write starts the core.
- R4: Status bit 2 (busy) is high from the edge that takes the fourth word until status bit 0 (completion) rises, exactly LAT clock edges after that fourth write.
- R5: Four reads of data-out return the result as bits 127:96, 95:64, 63:32 and 31:0, in that order.
- R6: The completion flag stays set across reads and idle cycles, and it falls only when control bit 7 is written as 1.
- R7: With key K, encryption gives rotl(x,13)^K, and decryption gives rotr(y^K,13), which is its inverse.
- R8: In CBC encryption, the core input is the block XOR the chaining vector, and the chaining vector then becomes the output block.
- R9: In CBC decryption, the output is the core's decrypt result XOR the chaining vector, and the chaining vector then becomes the ciphertext block just taken in.
- R10: The chaining-vector registers read back their current value, so a saved value written back restores the chain. Writes to them are ignored while busy.
- R11: The error flag (status bit 1) is set by a data-in write while busy, by a data-out read without completion, and by a data-out read after all four words are taken. It is sticky until control bit 8 is written as 1. The offending access otherwise has no effect.
- R12: Clearing enable discards a partly written input block and any pending output words, and data-in writes while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (advances data-out) |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| key_i | input | 128 | Prepared key for the core |
| rdata_o | output | 32 | Read data, combinational from addr_i |

## Verification
Read data is combinational from the address, so the value of every register is due in the same cycle as the access. The bench samples it 1 ns after driving the access at the falling edge. The completion flag is due exactly LAT rising edges after the edge that accepts the fourth input word. The bench polls status right after each of those edges and expects busy with no completion for the first LAT-1 of them, then completion without busy. Expected output words are computed from the key and the chaining state the bench keeps itself. They are queued when a block is sent and popped one per data-out read.

// File: rtl/cph_pkg.sv
package cph_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 4;
  localparam int BLK_W  = WORD_W * NWORDS;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOUT = 3'd3;

  localparam int B_EN      = 0;
  localparam int B_MODE    = 1;
  localparam int B_CHAIN   = 3;
  localparam int B_CLR_DN  = 7;
  localparam int B_CLR_ERR = 8;

  localparam logic [1:0] MODE_DEC  = 2'b10;
  localparam logic [2:0] CHAIN_CBC = 3'b001;
endpackage

// File: rtl/cph_core.sv
module cph_core #(
  parameter int BLK_W = 128,
  parameter int LAT   = 10,
  parameter int ROT   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dec_i,
  input  logic [BLK_W-1:0] data_i,
  input  logic [BLK_W-1:0] key_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [BLK_W-1:0] data_o
);
  localparam int CNT_W = $clog2(LAT);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] res_q;
  logic [BLK_W-1:0] xk;
  logic [BLK_W-1:0] res_d;

  always_comb begin
    xk = data_i ^ key_i;
    if (dec_i) res_d = (xk >> ROT) | (xk << (BLK_W - ROT));
    else       res_d = ((data_i << ROT) | (data_i >> (BLK_W - ROT))) ^ key_i;
  end

  assign fin_o  = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;
  assign data_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LAT - 1);
      res_q  <= res_d;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cph_in_gather.sv
module cph_in_gather #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic                     full_o,
  output logic [WORD_W*NWORDS-1:0] blk_o
);
  localparam int BLK_W = WORD_W * NWORDS;
  localparam int CNT_W = $clog2(NWORDS);

  logic [BLK_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  // first word ends up in the top slot after NWORDS shifts
  assign blk_o  = {sh_q[BLK_W-WORD_W-1:0], word_i};
  assign full_o = push_i && (cnt_q == CNT_W'(NWORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      sh_q  <= blk_o;
      cnt_q <= full_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cph_out_serve.sv
module cph_out_serve #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [WORD_W*NWORDS-1:0] blk_i,
  input  logic                     pop_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     empty_o
);
  localparam int BLK_W = WORD_W * NWORDS;
  localparam int CNT_W = $clog2(NWORDS + 1);

  logic [BLK_W-1:0] buf_q;
  logic [CNT_W-1:0] left_q;

  assign word_o  = buf_q[BLK_W-1 -: WORD_W];
  assign empty_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      buf_q  <= blk_i;
      left_q <= CNT_W'(NWORDS);
    end else if (clr_i) begin
      left_q <= '0;
    end else if (pop_i && !empty_o) begin
      buf_q  <= buf_q << WORD_W;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/cph_host.sv
module cph_host
  import cph_pkg::*;
#(
  parameter int LAT = 10,
  parameter int ROT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BLK_W-1:0]  key_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic             en_q, done_q, err_q;
  logic [1:0]       mode_q;
  logic [2:0]       chain_q;
  logic [BLK_W-1:0] cv_q;
  logic [BLK_W-1:0] ct_q;
  logic             job_dec_q, job_cbc_q;

  logic             wr_ctrl, wr_cv;
  logic             din_hit, din_ok, din_err;
  logic             dout_hit, dout_ok, dout_err;
  logic             in_full;
  logic [BLK_W-1:0] in_blk;
  logic             core_busy, core_fin;
  logic [BLK_W-1:0] core_in, core_out, out_blk;
  logic [WORD_W-1:0] out_word;
  logic             out_empty;
  logic             dec_now, cbc_now;
  logic [1:0]       cv_idx;

  assign dec_now  = (mode_q == MODE_DEC);
  assign cbc_now  = (chain_q == CHAIN_CBC);
  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_cv    = wr_en_i && addr_i[2] && !core_busy;
  assign cv_idx   = 2'd3 - addr_i[1:0];

  assign din_hit  = wr_en_i && (addr_i == A_DIN) && en_q;
  assign din_ok   = din_hit && !core_busy;
  assign din_err  = din_hit && core_busy;
  assign dout_hit = rd_en_i && (addr_i == A_DOUT);
  assign dout_ok  = dout_hit && done_q && !out_empty;
  assign dout_err = dout_hit && !dout_ok;

  assign core_in  = (cbc_now && !dec_now) ? (in_blk ^ cv_q) : in_blk;
  assign out_blk  = (job_cbc_q && job_dec_q) ? (core_out ^ cv_q) : core_out;

  cph_in_gather #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_q),
    .push_i (din_ok),
    .word_i (wdata_i),
    .full_o (in_full),
    .blk_o  (in_blk)
  );

  cph_core #(.BLK_W(BLK_W), .LAT(LAT), .ROT(ROT)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (in_full),
    .dec_i   (dec_now),
    .data_i  (core_in),
    .key_i   (key_i),
    .busy_o  (core_busy),
    .fin_o   (core_fin),
    .data_o  (core_out)
  );

  cph_out_serve #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_q),
    .load_i  (core_fin),
    .blk_i   (out_blk),
    .pop_i   (dout_ok),
    .word_o  (out_word),
    .empty_o (out_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      chain_q <= '0;
    end else if (wr_ctrl) begin
      en_q    <= wdata_i[B_EN];
      mode_q  <= wdata_i[B_MODE +: 2];
      chain_q <= wdata_i[B_CHAIN +: 3];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      job_dec_q <= 1'b0;
      job_cbc_q <= 1'b0;
      ct_q      <= '0;
    end else if (in_full) begin
      job_dec_q <= dec_now;
      job_cbc_q <= cbc_now;
      ct_q      <= in_blk;
    end
  end

  // chaining vector: host writes when idle, core completion in CBC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_q <= '0;
    end else if (core_fin && job_cbc_q) begin
      cv_q <= job_dec_q ? ct_q : core_out;
    end else if (wr_cv) begin
      cv_q[cv_idx*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (core_fin)                          done_q <= 1'b1;
      else if (wr_ctrl && wdata_i[B_CLR_DN]) done_q <= 1'b0;
      if (din_err || dout_err)                err_q <= 1'b1;
      else if (wr_ctrl && wdata_i[B_CLR_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[5:0] = {chain_q, mode_q, en_q};
      A_STAT:  rdata_o[2:0] = {core_busy, err_q, done_q};
      A_DOUT:  if (done_q && !out_empty) rdata_o = out_word;
      A_DIN:   rdata_o = '0;
      default: rdata_o = cv_q[cv_idx*WORD_W +: WORD_W];
    endcase
  end
endmodule

// File: rtl/cph_host_chk.sv
module cph_host_chk
  import cph_pkg::*;
#(
  parameter int LAT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic              en_q,
  input logic              done_q,
  input logic              err_q,
  input logic              busy,
  input logic              fin
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] run_q;
  logic          clr_dn;

  assign clr_dn = wr_en_i && (addr_i == A_CTRL) && wdata_i[B_CLR_DN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (!busy) run_q <= '0;
    else           run_q <= run_q + 1'b1;
  end

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |-> (run_q == CW'(LAT - 1)));

  p_fin_sets_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> done_q);

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_dn) |=> done_q);

  p_done_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_dn && !fin) |=> !done_q);

  p_err_busy_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIN && en_q && busy) |=> err_q);

  p_err_early_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_DOUT && !done_q) |=> err_q);
endmodule

bind cph_host cph_host_chk #(.LAT(LAT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_q    (en_q),
  .done_q  (done_q),
  .err_q   (err_q),
  .busy    (core_busy),
  .fin     (core_fin)
);

// File: tb/sim_cph_host.sv
`timescale 1ns/1ps
module sim_cph_host;
  localparam int LAT = 10;
  localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  cph_host #(.LAT(LAT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .key_i(KEY), .rdata_o(rdata_o)
  );

  function automatic logic [127:0] m_enc(logic [127:0] x);
    return ((x << 13) | (x >> 115)) ^ KEY;
  endfunction
  function automatic logic [127:0] m_dec(logic [127:0] y);
    logic [127:0] t = y ^ KEY;
    return (t >> 13) | (t << 115);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #0.1 d = rdata_o;
  endtask

  // driver: send block, push expected words MSW first
  task automatic send_block(logic [127:0] blk, logic [127:0] exp);
    for (int i = 3; i >= 0; i--) exp_q.push_back(exp[i*32 +: 32]);
    for (int i = 3; i >= 0; i--) bus_wr(3'd2, blk[i*32 +: 32]);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      peek(3'd1, s);
      if (s[0]) break;
      @(posedge clk_i); #1;
    end
  endtask

  // monitor: pop and compare each output word
  task automatic drain(string req);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      bus_rd(3'd3, d);
      if (exp_q.size() == 0) check(req, d, 32'hx);
      else check(req, d, exp_q.pop_front());
    end
  endtask

  task automatic clr_done(logic [31:0] ctrl);
    bus_wr(3'd0, ctrl | 32'h80);
  endtask

  task automatic write_cv(logic [127:0] v);
    for (int i = 0; i < 4; i++) bus_wr(3'(4 + i), v[(3-i)*32 +: 32]);
  endtask

  task automatic read_cv(string req, logic [127:0] exp);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      bus_rd(3'(4 + i), d);
      check(req, d, exp[(3-i)*32 +: 32]);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [127:0] pa, pb, iv, c1, c2, saved;
    pa = 128'h00112233_44556677_8899aabb_ccddeeff;
    pb = 128'hdeadbeef_01234567_89abcdef_fedcba98;
    iv = 128'ha5a5a5a5_5a5a5a5a_0f0f0f0f_f0f0f0f0;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1
    bus_rd(3'd0, d); check("R1 ctrl", d, 32'h0);
    bus_rd(3'd1, d); check("R1 stat", d, 32'h0);

    // R2 readback, clear bits read zero
    bus_wr(3'd0, 32'h1ad);
    bus_rd(3'd0, d); check("R2 ctrl readback", d, 32'h2d);
    bus_wr(3'd0, 32'h01);

    // R3/R4 timing, R5/R7 ECB encrypt
    send_block(pa, m_enc(pa));
    for (int k = 1; k <= LAT; k++) begin
      @(posedge clk_i); #1;
      peek(3'd1, d);
      if (k < LAT) check("R4 busy no done", d[2:0], 3'b100);
      else         check("R4 done at LAT", d[2:0], 3'b001);
    end
    drain("R5 R7 ecb enc");
    repeat (5) @(posedge clk_i);
    bus_rd(3'd1, d); check("R6 done sticky", d[0], 1'b1);
    clr_done(32'h01);
    bus_rd(3'd1, d); check("R6 done cleared", d[0], 1'b0);

    // R7 ECB decrypt via mode 2'b10
    bus_wr(3'd0, 32'h05);
    send_block(m_enc(pa), pa);
    wait_done();
    drain("R7 R2 ecb dec");
    clr_done(32'h05);

    // R11 early read: error, sticky, cleared by bit 8
    bus_rd(3'd3, d); check("R11 early read data", d, 32'h0);
    bus_rd(3'd1, d); check("R11 err set", d[1], 1'b1);
    bus_wr(3'd0, 32'h105);
    bus_rd(3'd1, d); check("R11 err cleared", d[1], 1'b0);

    // R8 CBC encrypt
    c1 = m_enc(pa ^ iv);
    c2 = m_enc(pb ^ c1);
    bus_wr(3'd0, 32'h09);
    write_cv(iv);
    read_cv("R10 cv write", iv);
    send_block(pa, c1); wait_done(); drain("R8 cbc enc 1"); clr_done(32'h09);
    send_block(pb, c2); wait_done(); drain("R8 cbc enc 2"); clr_done(32'h09);
    read_cv("R8 cv is last ct", c2);

    // R9 CBC decrypt with save/restore of the chain
    bus_wr(3'd0, 32'h0d);
    write_cv(iv);
    send_block(c1, pa); wait_done(); drain("R9 cbc dec 1"); clr_done(32'h0d);
    read_cv("R9 cv is ct", c1);
    saved = c1;
    write_cv(128'h1);
    write_cv(saved);
    send_block(c2, pb); wait_done(); drain("R10 R9 resume"); clr_done(32'h0d);

    // R11 write while busy ignored; R10 cv write while busy ignored
    bus_wr(3'd0, 32'h01);
    write_cv(iv);
    send_block(pb, m_enc(pb));
    bus_wr(3'd2, 32'hffffffff);
    bus_wr(3'd4, 32'h12345678);
    wait_done();
    bus_rd(3'd1, d); check("R11 busy write err", d[1], 1'b1);
    drain("R11 result intact");
    read_cv("R10 busy cv write ignored", iv);
    bus_rd(3'd3, d);
    bus_rd(3'd1, d); check("R11 read past end err", d[1], 1'b1);
    bus_wr(3'd0, 32'h181);

    // R12 disable clears partial input
    bus_wr(3'd2, 32'h11111111);
    bus_wr(3'd2, 32'h22222222);
    bus_wr(3'd0, 32'h00);
    bus_wr(3'd2, 32'h33333333);
    bus_wr(3'd0, 32'h01);
    send_block(pa, m_enc(pa));
    wait_done();
    drain("R12 fresh block");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule